// File: doc/BRIEF.md
# Dual-Path SPI Bit-Clock Divider

This block turns a fast source clock into the serial bit clock of an SPI master. Two divider laws are available and a select input picks one at run time. The power-of-two law divides the source by four times two to the power of a 3-bit code, which gives divisors from 4 up to 512. The linear law divides the source by two times one more than an 8-bit code, which gives any even divisor from 2 to 512. Both laws reduce to a half-period count in source cycles. A single down-counter loaded with that count toggles the serial clock on each terminal count, so the high and low phases are always the same length.

The block runs while the run input is high. While it is stopped, the serial clock rests at the level given by the polarity input. An optional lead-in delay, counted in source cycles, can hold back the first clock edge after a start so that the chip-select has time to settle. A pulse output marks every half-period boundary, for use by the shift logic that sits next to the divider. The power-of-two code in effect can be read back. It reads as zero whenever the divider is not toggling, because the code has no meaning in that state.

Top module: `sclk_dual_div`

## Requirements
- R1: While reset is asserted, halfTick and delayBusy are 0, heldPow2Code is 0 and sclk equals cpol.
- R2: While run is low (and was low on the previous cycle), sclk follows cpol combinationally and halfTick stays 0.
- R3: With linSel = 0 the half-period is 2^(pow2Code+1) source cycles, so the sclk period is 4·2^pow2Code cycles.
- R4: With linSel = 1 the half-period is linCode+1 source cycles, so the sclk period is 2·(linCode+1) cycles.
- R5: halfTick is a one-cycle pulse in the same cycle as each sclk transition; the first transition after a start leaves the cpol level.
- R6: Without a delay, the k-th halfTick after the edge that samples run high comes exactly k half-periods later (equal spacing, 50% duty).
- R7: A change of linCode, pow2Code or linSel while running leaves the current half-period unchanged; the new half-period starts at the next sclk transition.
- R8: With csDelayEn = 1 and csDelay = D > 0, delayBusy is high for D cycles after the start and every sclk transition comes D cycles later than it would without the delay.
- R9: With csDelayEn = 0, or csDelay = 0, no delay is inserted and delayBusy stays 0.
- R10: While toggling, heldPow2Code shows the power-of-two code loaded at the last transition; while not toggling it reads 0.
- R11: When run falls, sclk returns to cpol and halfTick stops one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Divider runs while high |
| cpol | input | 1 | Idle level of sclk |
| linSel | input | 1 | 1 selects the linear law, 0 the power-of-two law |
| pow2Code | input | 3 | Exponent code of the power-of-two law |
| linCode | input | 8 | Code of the linear law |
| csDelayEn | input | 1 | Enables the lead-in delay |
| csDelay | input | 16 | Lead-in delay in source cycles |
| sclk | output | 1 | Serial bit clock, 50% duty |
| halfTick | output | 1 | One-cycle pulse at each sclk transition |
| delayBusy | output | 1 | High while the lead-in delay counts |
| heldPow2Code | output | 3 | Power-of-two code in effect, 0 when not toggling |

## Verification
A new divider code can arrive in the same cycle as a terminal count, or a few cycles before one. In both cases the reload at that boundary has to take the new value while the half-period already running keeps the old one. The bench changes linCode, and in a second run flips linSel from the power-of-two law to the linear law, at a known cycle between two transitions. It then compares the cycle index of each later halfTick with the sum of the old remaining count and the new half-periods. In the same way, the end of the lead-in delay coincides with the first counter load, and this is judged by checking that the first transition comes exactly delay plus one half-period after the start.

// File: rtl/sclk_dual_div_pkg.sv
package sclk_dual_div_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DELAY = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic park;     // hold sclk register at the idle level
    logic reload;   // load counter with the live half-period
    logic dec;      // decrement counter
    logic flip;     // toggle sclk, pulse halfTick
    logic running;  // sclk output comes from the toggle register
  } dp_ctl_t;

endpackage

// File: rtl/sclk_dual_div_ctrl.sv
module sclk_dual_div_ctrl
  import sclk_dual_div_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             csDelayEn,
  input  logic [DLY_W-1:0] csDelay,
  input  logic             tc,
  output dp_ctl_t          ctl,
  output logic             delayBusy
);

  phase_e           phase, phaseNext;
  logic [DLY_W-1:0] dlyCnt, dlyNext;
  logic             wantDelay;

  assign wantDelay = csDelayEn && (csDelay != '0);

  always_comb begin
    phaseNext = phase;
    dlyNext   = dlyCnt;
    ctl       = '0;
    unique case (phase)
      PH_IDLE: begin
        ctl.park   = 1'b1;
        ctl.reload = 1'b1;
        if (run) begin
          if (wantDelay) begin
            phaseNext = PH_DELAY;
            dlyNext   = csDelay - 1'b1;
          end else begin
            phaseNext = PH_RUN;
          end
        end
      end
      PH_DELAY: begin
        ctl.park   = 1'b1;
        ctl.reload = 1'b1;
        if (!run) begin
          phaseNext = PH_IDLE;
        end else if (dlyCnt == '0) begin
          phaseNext = PH_RUN;
        end else begin
          dlyNext = dlyCnt - 1'b1;
        end
      end
      PH_RUN: begin
        ctl.running = 1'b1;
        if (!run) begin
          phaseNext = PH_IDLE;
        end else if (tc) begin
          ctl.flip   = 1'b1;
          ctl.reload = 1'b1;
        end else begin
          ctl.dec = 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      dlyCnt <= '0;
    end else begin
      phase  <= phaseNext;
      dlyCnt <= dlyNext;
    end
  end

  assign delayBusy = (phase == PH_DELAY);

endmodule

// File: rtl/sclk_dual_div_dp.sv
module sclk_dual_div_dp
  import sclk_dual_div_pkg::*;
#(
  parameter int POW2_W = 3,
  parameter int LIN_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic              cpol,
  input  logic              linSel,
  input  logic [POW2_W-1:0] pow2Code,
  input  logic [LIN_W-1:0]  linCode,
  output logic              tc,
  output logic              sclk,
  output logic              halfTick,
  output logic [POW2_W-1:0] heldPow2Code
);

  localparam int NCODES = 2 ** POW2_W;

  logic [CNT_W-1:0]  pow2HalfM1 [NCODES];
  logic [CNT_W-1:0]  linHalfM1;
  logic [CNT_W-1:0]  halfM1;
  logic [CNT_W-1:0]  cnt;
  logic              sclkQ;
  logic              tickQ;
  logic [POW2_W-1:0] heldQ;

  // Power-of-two law: half-period = 2^(code+1), stored minus one
  for (genvar g = 0; g < NCODES; g++) begin : g_pow2
    localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'((64'd1 << (g + 1)) - 64'd1);
    assign pow2HalfM1[g] = HALF_M1;
  end

  // Linear law: half-period = code + 1, stored minus one
  assign linHalfM1 = CNT_W'(linCode);
  assign halfM1    = linSel ? linHalfM1 : pow2HalfM1[pow2Code];
  assign tc        = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      sclkQ <= 1'b0;
      tickQ <= 1'b0;
      heldQ <= '0;
    end else begin
      tickQ <= ctl.flip;
      if (ctl.reload) begin
        cnt   <= halfM1;
        heldQ <= pow2Code;
      end else if (ctl.dec) begin
        cnt <= cnt - 1'b1;
      end
      if (ctl.park) begin
        sclkQ <= cpol;
      end else if (ctl.flip) begin
        sclkQ <= ~sclkQ;
      end
    end
  end

  assign sclk         = ctl.running ? sclkQ : cpol;
  assign halfTick     = tickQ;
  assign heldPow2Code = ctl.running ? heldQ : '0;

endmodule

// File: rtl/sclk_dual_div.sv
module sclk_dual_div
  import sclk_dual_div_pkg::*;
#(
  parameter int POW2_W = 3,
  parameter int LIN_W  = 8,
  parameter int DLY_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  input  logic              cpol,
  input  logic              linSel,
  input  logic [POW2_W-1:0] pow2Code,
  input  logic [LIN_W-1:0]  linCode,
  input  logic              csDelayEn,
  input  logic [DLY_W-1:0]  csDelay,
  output logic              sclk,
  output logic              halfTick,
  output logic              delayBusy,
  output logic [POW2_W-1:0] heldPow2Code
);

  localparam int P2_BITS = 2 ** POW2_W;
  localparam int CNT_W   = (LIN_W > P2_BITS) ? LIN_W : P2_BITS;

  dp_ctl_t ctl;
  logic    tc;

  sclk_dual_div_ctrl #(.DLY_W(DLY_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .run       (run),
    .csDelayEn (csDelayEn),
    .csDelay   (csDelay),
    .tc        (tc),
    .ctl       (ctl),
    .delayBusy (delayBusy)
  );

  sclk_dual_div_dp #(.POW2_W(POW2_W), .LIN_W(LIN_W), .CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .cpol         (cpol),
    .linSel       (linSel),
    .pow2Code     (pow2Code),
    .linCode      (linCode),
    .tc           (tc),
    .sclk         (sclk),
    .halfTick     (halfTick),
    .heldPow2Code (heldPow2Code)
  );

endmodule

// File: rtl/sclk_dual_div_chk.sv
module sclk_dual_div_chk #(
  parameter int POW2_W = 3,
  parameter int DLY_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              run,
  input logic              cpol,
  input logic              csDelayEn,
  input logic [DLY_W-1:0]  csDelay,
  input logic              sclk,
  input logic              halfTick,
  input logic              delayBusy,
  input logic [POW2_W-1:0] heldPow2Code
);

  // R5
  tick_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    halfTick |-> (sclk != $past(sclk)));

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!run && $past(!run)) |-> (sclk == cpol && !halfTick));

  // R10
  held_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!run && $past(!run)) |-> (heldPow2Code == '0));

  // R9
  delay_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(delayBusy) |-> ($past(csDelayEn) && $past(csDelay) != '0));

  // R11
  tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    halfTick |-> $past(run));

  // R8
  busy_no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    delayBusy |-> !halfTick);

endmodule

bind sclk_dual_div sclk_dual_div_chk #(.POW2_W(POW2_W), .DLY_W(DLY_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .run          (run),
  .cpol         (cpol),
  .csDelayEn    (csDelayEn),
  .csDelay      (csDelay),
  .sclk         (sclk),
  .halfTick     (halfTick),
  .delayBusy    (delayBusy),
  .heldPow2Code (heldPow2Code)
);

// File: tb/sclk_dual_div_bench.sv
`timescale 1ns/1ps
module sclk_dual_div_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        run = 1'b0;
  logic        cpol = 1'b0;
  logic        linSel = 1'b0;
  logic [2:0]  pow2Code = '0;
  logic [7:0]  linCode = '0;
  logic        csDelayEn = 1'b0;
  logic [15:0] csDelay = '0;
  logic        sclk, halfTick, delayBusy;
  logic [2:0]  heldPow2Code;

  int nChecks = 0;
  int nFail   = 0;
  int n       = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  sclk_dual_div u_sclk_dual_div (
    .clk(clk), .rstN(rstN), .run(run), .cpol(cpol), .linSel(linSel),
    .pow2Code(pow2Code), .linCode(linCode), .csDelayEn(csDelayEn),
    .csDelay(csDelay), .sclk(sclk), .halfTick(halfTick),
    .delayBusy(delayBusy), .heldPow2Code(heldPow2Code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    n++;
  endtask

  task automatic nextTick(output int at);
    int guard = 0;
    do begin
      step();
      guard++;
    end while (!halfTick && guard < 2000);
    at = n;
  endtask

  task automatic stopRun(input bit pol);
    run = 1'b0;
    step();
    check(sclk == pol, "R11 sclk back to idle", sclk, pol);
    check(heldPow2Code == 0, "R10 held code zero when stopped", heldPow2Code, 0);
    step();
    check(!halfTick, "R11 no tick after stop", halfTick, 0);
  endtask

  task automatic trial(input bit pol, input bit sel, input int p2, input int lin,
                       input bit en, input int d, input int ticks, input string req);
    int h  = sel ? lin + 1 : (2 << p2);
    int dd = (en && d > 0) ? d : 0;
    int at;
    cpol = pol; linSel = sel; pow2Code = 3'(p2); linCode = 8'(lin);
    csDelayEn = en; csDelay = 16'(d);
    run = 1'b1;
    n = -1;
    step();
    check(delayBusy == (dd > 0), "R8 R9 delayBusy after start", delayBusy, dd > 0);
    for (int j = 1; j <= ticks; j++) begin
      nextTick(at);
      check(at == dd + h * j, req, at, dd + h * j);
      check(sclk == (pol ^ j[0]), "R5 sclk level at tick", sclk, pol ^ j[0]);
      if (j == 1) check(heldPow2Code == 3'(p2), "R10 held code", heldPow2Code, p2);
    end
    stopRun(pol);
  endtask

  initial begin : main
    int at;
    // R1 reset state
    cpol = 1'b1;
    repeat (3) @(negedge clk);
    check(sclk == 1'b1, "R1 sclk at reset", sclk, 1);
    check(!halfTick && !delayBusy, "R1 tick/busy at reset", {halfTick, delayBusy}, 0);
    check(heldPow2Code == 0, "R1 held code at reset", heldPow2Code, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 idle follows cpol
    for (int i = 0; i < 8; i++) begin
      cpol = i[0];
      linCode = 8'(i * 37);
      #1;
      check(sclk == cpol && !halfTick, "R2 idle level", sclk, cpol);
      @(negedge clk);
    end

    // R3 full sweep of the power-of-two law, both polarities
    for (int pol = 0; pol < 2; pol++)
      for (int c = 0; c < 8; c++)
        trial(pol[0], 1'b0, c, 200, 1'b0, 0, 3, "R3 R6 pow2 tick timing");

    // R4 full sweep of the linear law
    for (int c = 0; c < 256; c++)
      trial(c[1], 1'b1, 5, c, 1'b0, 0, 2, "R4 R6 linear tick timing");

    // R8 lead-in delay
    trial(1'b0, 1'b1, 0, 2, 1'b1, 5, 3, "R8 delayed timing");
    trial(1'b1, 1'b0, 2, 0, 1'b1, 1, 3, "R8 delay of one");
    trial(1'b0, 1'b1, 0, 0, 1'b1, 300, 2, "R8 long delay");
    // R9 delay disabled or zero
    trial(1'b0, 1'b1, 0, 3, 1'b0, 7, 3, "R9 disabled delay");
    trial(1'b1, 1'b1, 0, 3, 1'b1, 0, 3, "R9 zero delay");

    // R7 code change mid half-period
    cpol = 1'b0; linSel = 1'b1; linCode = 8'd9; csDelayEn = 1'b0;
    run = 1'b1; n = -1;
    nextTick(at);
    check(at == 10, "R7 first tick old code", at, 10);
    while (n < 13) step();
    linCode = 8'd3;
    nextTick(at);
    check(at == 20, "R7 current half keeps old code", at, 20);
    nextTick(at);
    check(at == 24, "R7 new code next half", at, 24);
    nextTick(at);
    check(at == 28, "R7 new code steady", at, 28);
    stopRun(1'b0);

    // R7 law switch mid half-period
    cpol = 1'b1; linSel = 1'b0; pow2Code = 3'd1; linCode = 8'd1;
    run = 1'b1; n = -1;
    nextTick(at);
    check(at == 4, "R7 pow2 before switch", at, 4);
    step();
    linSel = 1'b1;
    pow2Code = 3'd6;
    nextTick(at);
    check(at == 8, "R7 old law finishes", at, 8);
    check(heldPow2Code == 3'd6, "R10 held code after reload", heldPow2Code, 6);
    nextTick(at);
    check(at == 10, "R7 linear law after switch", at, 10);
    nextTick(at);
    check(at == 12, "R7 linear law steady", at, 12);
    stopRun(1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule